// File: doc/BRIEF.md
# NAND Die Array Model

This block is a synthesizable, scaled-down stand-in for one NAND flash die. It holds its pages in on-chip storage so that flash controller logic can be exercised in simulation or on an FPGA. The row address is a block number plus a page number. Commands arrive on a plain command port, one per cycle, and are taken only while the die is ready. Page data moves one byte at a time through a page cache register. Data in and data out each use a valid/ready stream.

The model keeps the write rules of real flash. Erase works only on a whole block. Pages in a block are programmed in strictly ascending order. A page cannot be programmed twice without an erase of its block. A command that breaks a rule is rejected, and a pass/fail status bit reports it. Each operation keeps the die busy for its own fixed number of cycles. The read, program and erase busy times are in the ratio 25 : 220 : 1500, multiplied by a cycles-per-microsecond parameter. Every block has a saturating erase counter, which a query command can read.

Stream rules:
- A write byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only in the load phase that follows a load command, and only while page columns remain.
- A read byte is taken on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid` and `rd_data` hold their values.
- Any accepted command ends a data phase that is in progress.

Top module: `nand_die_model`

## Requirements
- R1: After reset, `sts_ready`=1 and `sts_fail`=0. `wr_ready` and `rd_valid` are 0, every block's erase count is 0, and every page reads back as all 0xFF bytes.
- R2: A read (`cmd_op`=1) keeps `sts_ready` low for exactly 25·CYC_PER_US cycles after the accepting edge. The page then streams out on `rd_*`, one byte per handshake, from column 0 to column PAGE_BYTES-1. Main bytes come first, then spare bytes. `rd_valid` falls after the last byte, and a stalled byte stays stable.
- R3: A load (`cmd_op`=2) clears the cache to 0xFF and latches the target row. Bytes then enter on `wr_*` from column 0, and columns never written stay 0xFF. A confirm (`cmd_op`=3) that passes keeps the die busy for exactly 220·CYC_PER_US cycles and writes the cache to the target page. A byte handshaken in the same cycle as the confirm is included in the page.
- R4: An erase (`cmd_op`=4) keeps the die busy for exactly 1500·CYC_PER_US cycles. Afterwards every page of that block reads as 0xFF, and page 0 of the block may be programmed again. Other blocks are unchanged.
- R5: A confirm whose target page is not the block's next page in order is rejected. This covers skipping ahead, a page below the next page, and any page in a full block. A rejected confirm sets `sts_fail`, does not raise busy and leaves the array unchanged.
- R6: A confirm to a page that was already programmed since its block's last erase is rejected, and that page keeps its data.
- R7: A block may be filled over several separate program sessions. Reads, queries and work on other blocks may come between them, as long as the ascending page order holds.
- R8: Commands presented while busy are ignored. They change no state, no erase count and no busy length.
- R9: `sts_fail` is updated only when a command is accepted. It stays set until the next accepted command, which clears it unless that command is itself a rejected confirm.
- R10: A confirm is rejected if the command accepted just before it was not a load.
- R11: A query (`cmd_op`=5) puts the addressed block's erase count on `wear_count` one edge after acceptance. The count rises by one on each erase and saturates at 2^WEAR_W-1. Opcodes 0, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, erases the whole array |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 1 read, 2 load, 3 confirm, 4 erase, 5 query |
| cmd_block | input | $clog2(NUM_BLOCKS) | Block address |
| cmd_page | input | $clog2(PAGES_PER_BLOCK) | Page address within the block |
| sts_ready | output | 1 | High when the die is not busy |
| sts_fail | output | 1 | Result of the last accepted command |
| wear_count | output | WEAR_W | Erase count returned by the last query |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Cache accepts a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |

## Verification
Two functions can fall in the same cycle. The first is a write-stream handshake on the same edge that accepts a confirm. The bench provokes it by presenting the final load byte together with the confirm, then reads the page back; the byte must appear at its column. The second is a command arriving as busy ends. The bench holds an erase on the command port for the whole busy time of a program and drops it at the first ready sample. The busy length must equal the program time exactly, and the erase count and the programmed page must show that the erase never happened.

// File: rtl/nand_pkg.sv
package nand_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_READ    = 3'd1,
    OP_LOAD    = 3'd2,
    OP_CONFIRM = 3'd3,
    OP_ERASE   = 3'd4,
    OP_WEAR    = 3'd5
  } nand_op_e;

  typedef enum logic [2:0] {
    M_IDLE,
    M_DIN,
    M_DOUT,
    M_ARD,
    M_APR,
    M_AER
  } nand_mode_e;

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R8

endmodule

// File: rtl/nand_block_rules.sv
module nand_block_rules #(
  parameter int NUM_BLOCKS = 2,
  parameter int PAGES      = 64,
  parameter int WEAR_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NUM_BLOCKS)-1:0] blk_i,
  input  logic [$clog2(PAGES)-1:0]  page_i,
  input  logic                      do_prog,
  input  logic                      do_erase,
  output logic                      prog_ok,
  output logic                      page_written,
  output logic [WEAR_W-1:0]         wear_o
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int PG_W  = $clog2(PAGES);
  localparam int PTR_W = PG_W + 1;
  localparam logic [WEAR_W-1:0] WEAR_MAX = '1;

  logic [PAGES-1:0]  written [NUM_BLOCKS];
  logic [PTR_W-1:0]  next_pg [NUM_BLOCKS];
  logic [WEAR_W-1:0] wear    [NUM_BLOCKS];

  function automatic logic [PAGES-1:0] below_mask(input logic [PTR_W-1:0] lim);
    logic [PAGES-1:0] m;
    for (int i = 0; i < PAGES; i++) m[i] = (PTR_W'(i) < lim);
    return m;
  endfunction

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [PAGES-1:0]  wr_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [WEAR_W-1:0] wear_q;
    logic              hit;

    assign hit = (blk_i == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_q   <= '0;
        ptr_q  <= '0;
        wear_q <= '0;
      end else if (do_erase && hit) begin
        wr_q  <= '0;
        ptr_q <= '0;
        if (wear_q != WEAR_MAX) wear_q <= wear_q + 1'b1;
      end else if (do_prog && hit) begin
        wr_q[page_i] <= 1'b1;
        ptr_q        <= ptr_q + 1'b1;
      end
    end

    assign written[b] = wr_q;
    assign next_pg[b] = ptr_q;
    assign wear[b]    = wear_q;

    AST_ORDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q == below_mask(ptr_q)); // R5
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PTR_W'(PAGES)); // R5
    AST_WEAR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (wear_q == WEAR_MAX) |=> (wear_q == WEAR_MAX)); // R11
  end

  assign page_written = written[blk_i][page_i];
  assign prog_ok      = ({1'b0, page_i} == next_pg[blk_i]) && !page_written;
  assign wear_o       = wear[blk_i];

endmodule

// File: rtl/nand_page_cache.sv
module nand_page_cache #(
  parameter int PAGE_BYTES = 33
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fill_ones,
  input  logic                             col_clr,
  input  logic                             din_en,
  input  logic                             dout_en,
  input  logic                             arr_step,
  input  logic                             arr_fill,
  input  logic [7:0]                       arr_byte,
  input  logic                             wr_valid,
  input  logic [7:0]                       wr_data,
  output logic                             wr_ready,
  input  logic                             rd_ready,
  output logic                             rd_valid,
  output logic [7:0]                       cur_byte,
  output logic [$clog2(PAGE_BYTES+1)-1:0]  col,
  output logic                             in_range
);

  localparam int COL_W = $clog2(PAGE_BYTES + 1);

  logic [7:0]       cache [PAGE_BYTES];
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] idx;
  logic             wr_fire, rd_fire, step;

  assign in_range = (col_q < COL_W'(PAGE_BYTES));
  assign idx      = in_range ? col_q : '0;
  assign cur_byte = cache[idx];
  assign wr_ready = din_en && in_range;
  assign rd_valid = dout_en && in_range;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign step     = wr_fire || rd_fire || (arr_step && in_range);
  assign col      = col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) cache[i] <= 8'hFF;
    end else if (fill_ones) begin
      for (int i = 0; i < PAGE_BYTES; i++) cache[i] <= 8'hFF;
    end else if (wr_fire) begin
      cache[idx] <= wr_data;
    end else if (arr_step && arr_fill && in_range) begin
      cache[idx] <= arr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       col_q <= COL_W'(PAGE_BYTES);
    else if (col_clr) col_q <= '0;
    else if (step)    col_q <= col_q + 1'b1;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !col_clr) |=> (rd_valid && $stable(cur_byte))); // R2
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid)); // R3

endmodule

// File: rtl/nand_die_model.sv
module nand_die_model
  import nand_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MAIN_BYTES      = 32,
  parameter int CYC_PER_US      = 2,
  parameter int WEAR_W          = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [2:0]                         cmd_op,
  input  logic [$clog2(NUM_BLOCKS)-1:0]      cmd_block,
  input  logic [$clog2(PAGES_PER_BLOCK)-1:0] cmd_page,
  output logic                               sts_ready,
  output logic                               sts_fail,
  output logic [WEAR_W-1:0]                  wear_count,
  input  logic                               wr_valid,
  output logic                               wr_ready,
  input  logic [7:0]                         wr_data,
  output logic                               rd_valid,
  input  logic                               rd_ready,
  output logic [7:0]                         rd_data
);

  localparam int BLK_W       = $clog2(NUM_BLOCKS);
  localparam int PG_W        = $clog2(PAGES_PER_BLOCK);
  localparam int SPARE_BYTES = MAIN_BYTES / 32;
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W       = $clog2(PAGE_BYTES + 1);
  localparam int TOTAL_BYTES = NUM_BLOCKS * PAGES_PER_BLOCK * PAGE_BYTES;
  localparam int ADDR_W      = $clog2(TOTAL_BYTES);
  localparam int T_READ      = 25 * CYC_PER_US;
  localparam int T_PROG      = 220 * CYC_PER_US;
  localparam int T_ERASE     = 1500 * CYC_PER_US;
  localparam int TMR_W       = $clog2(T_ERASE + 1);

  // Command decode
  logic busy, t_last, t_load;
  logic [TMR_W-1:0] t_val;
  logic op_known, accept, is_rd, is_ld, is_cf, is_er, is_wq;
  logic prog_ok, page_written, prog_go;
  logic [WEAR_W-1:0] wear_of;
  logic [BLK_W-1:0]  rule_blk;
  logic [PG_W-1:0]   rule_pg;

  // State
  nand_mode_e        mode_q;
  logic              fail_q, load_ok_q, rd_written_q;
  logic [BLK_W-1:0]  tgt_blk_q;
  logic [PG_W-1:0]   tgt_pg_q;
  logic [WEAR_W-1:0] wear_q;

  // Cache and array
  logic [COL_W-1:0]  col;
  logic              col_in_range;
  logic [7:0]        cur_byte, arr_byte;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]        mem [TOTAL_BYTES];

  assign is_rd    = (cmd_op == OP_READ);
  assign is_ld    = (cmd_op == OP_LOAD);
  assign is_cf    = (cmd_op == OP_CONFIRM);
  assign is_er    = (cmd_op == OP_ERASE);
  assign is_wq    = (cmd_op == OP_WEAR);
  assign op_known = is_rd || is_ld || is_cf || is_er || is_wq;
  assign accept   = cmd_valid && !busy && op_known;

  assign rule_blk = is_cf ? tgt_blk_q : cmd_block;
  assign rule_pg  = is_cf ? tgt_pg_q  : cmd_page;
  assign prog_go  = accept && is_cf && load_ok_q && prog_ok;

  assign t_load = accept && (is_rd || prog_go || is_er);
  assign t_val  = is_rd ? TMR_W'(T_READ) : (is_er ? TMR_W'(T_ERASE) : TMR_W'(T_PROG));

  nand_busy_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .busy     (busy),
    .last     (t_last)
  );

  nand_block_rules #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGES      (PAGES_PER_BLOCK),
    .WEAR_W     (WEAR_W)
  ) u_rules (
    .clk          (clk),
    .rst_n        (rst_n),
    .blk_i        (rule_blk),
    .page_i       (rule_pg),
    .do_prog      (prog_go),
    .do_erase     (accept && is_er),
    .prog_ok      (prog_ok),
    .page_written (page_written),
    .wear_o       (wear_of)
  );

  nand_page_cache #(.PAGE_BYTES(PAGE_BYTES)) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_ones (accept && is_ld),
    .col_clr   (accept || (t_last && mode_q == M_ARD)),
    .din_en    (mode_q == M_DIN),
    .dout_en   (mode_q == M_DOUT),
    .arr_step  (mode_q == M_ARD || mode_q == M_APR),
    .arr_fill  (mode_q == M_ARD),
    .arr_byte  (arr_byte),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .cur_byte  (cur_byte),
    .col       (col),
    .in_range  (col_in_range)
  );

  // Byte address of the current column within the target page
  assign arr_addr = ADDR_W'(int'({tgt_blk_q, tgt_pg_q}) * PAGE_BYTES + int'(col));
  assign arr_byte = rd_written_q ? mem[arr_addr] : 8'hFF;

  always_ff @(posedge clk) begin
    if (mode_q == M_APR && col_in_range) mem[arr_addr] <= cur_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= M_IDLE;
      fail_q       <= 1'b0;
      load_ok_q    <= 1'b0;
      rd_written_q <= 1'b0;
      tgt_blk_q    <= '0;
      tgt_pg_q     <= '0;
      wear_q       <= '0;
    end else if (accept) begin
      fail_q    <= is_cf && !(load_ok_q && prog_ok);
      load_ok_q <= is_ld;
      if (is_rd || is_ld) begin
        tgt_blk_q <= cmd_block;
        tgt_pg_q  <= cmd_page;
      end
      if (is_rd) rd_written_q <= page_written;
      if (is_wq) wear_q <= wear_of;
      unique case (1'b1)
        is_rd:   mode_q <= M_ARD;
        is_ld:   mode_q <= M_DIN;
        is_cf:   mode_q <= prog_go ? M_APR : M_IDLE;
        is_er:   mode_q <= M_AER;
        default: mode_q <= M_IDLE;
      endcase
    end else if (t_last) begin
      mode_q <= (mode_q == M_ARD) ? M_DOUT : M_IDLE;
    end
  end

  assign sts_ready  = !busy;
  assign sts_fail   = fail_q;
  assign wear_count = wear_q;
  assign rd_data    = cur_byte;

  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_rd) |=> busy); // R2
  AST_NO_STREAM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_ready && !rd_valid)); // R3
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_fail) |-> sts_ready); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tgt_blk_q) && $stable(tgt_pg_q) && $stable(load_ok_q))); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_fail && !accept) |=> sts_fail); // R9

endmodule

// File: tb/nand_die_model_bench.sv
module nand_die_model_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 2;
  localparam int PGS  = 64;
  localparam int MAIN = 32;
  localparam int PB   = MAIN + MAIN / 32;
  localparam int CPU  = 2;
  localparam int TR   = 25 * CPU;
  localparam int TP   = 220 * CPU;
  localparam int TE   = 1500 * CPU;
  localparam int WMAX = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [0:0] cmd_block = 1'b0;
  logic [5:0] cmd_page = 6'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_ready = 1'b0;
  logic       sts_ready, sts_fail, wr_ready, rd_valid;
  logic [3:0] wear_count;
  logic [7:0] rd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_die_model u_nand_die_model (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_block(cmd_block), .cmd_page(cmd_page), .sts_ready(sts_ready),
    .sts_fail(sts_fail), .wear_count(wear_count), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model
  logic [7:0] bmem [NB][PGS][PB];
  bit         bwr [NB][PGS];
  int         bptr [NB];
  int         bwear [NB];
  bit         bload = 1'b0;
  int         tb_blk = 0, tb_pg = 0;
  logic [7:0] bcache [PB];

  function automatic logic [7:0] exp_byte(int b, int p, int i);
    return bwr[b][p] ? bmem[b][p][i] : 8'hFF;
  endfunction

  function automatic bit confirm_passes();
    return bload && !bwr[tb_blk][tb_pg] && (tb_pg == bptr[tb_blk]);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(int op, int b, int p);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_block = b[0:0]; cmd_page = p[5:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!sts_ready && n < TE + 10) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(int b, int p, string req);
    int n, idx, guard;
    issue(1, b, p);
    bload = 1'b0;
    chk(sts_fail == 1'b0, "R9", "fail after read", sts_fail, 0);
    busy_len(n);
    chk(n == TR, "R2", "read busy cycles", n, TR);
    idx = 0; guard = 0;
    while (idx < PB && guard < 4000) begin
      rd_ready = ($urandom % 3) != 0;
      if (rd_valid && rd_ready) begin
        chk(rd_data == exp_byte(b, p, idx), req, "read byte", rd_data, exp_byte(b, p, idx));
        idx++;
      end
      guard++;
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk(idx == PB && rd_valid == 1'b0, "R2", "stream length", idx, PB);
  endtask

  task automatic do_load(int b, int p, int n, bit collide);
    int idx, last;
    issue(2, b, p);
    bload = 1'b1; tb_blk = b; tb_pg = p;
    for (int i = 0; i < PB; i++) bcache[i] = 8'hFF;
    chk(sts_fail == 1'b0, "R9", "fail after load", sts_fail, 0);
    last = collide ? n - 1 : n;
    idx = 0;
    while (idx < last) begin
      wr_valid = ($urandom % 4) != 0;
      wr_data  = 8'($urandom);
      if (wr_valid && wr_ready) begin
        bcache[idx] = wr_data;
        idx++;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
    if (collide) begin
      wr_valid = 1'b1;
      wr_data  = 8'($urandom);
      bcache[n - 1] = wr_data;
      chk(wr_ready == 1'b1, "R3", "ready for final byte", wr_ready, 1);
    end
  endtask

  task automatic confirm_check(string req);
    int n;
    bit ok;
    ok = confirm_passes();
    bload = 1'b0;
    chk(sts_fail == !ok, req, "fail after confirm", sts_fail, !ok);
    if (ok) begin
      for (int i = 0; i < PB; i++) bmem[tb_blk][tb_pg][i] = bcache[i];
      bwr[tb_blk][tb_pg] = 1'b1;
      bptr[tb_blk]++;
      busy_len(n);
      chk(n == TP, "R3", "program busy cycles", n, TP);
    end else begin
      chk(sts_ready == 1'b1, req, "no busy on reject", sts_ready, 1);
    end
  endtask

  task automatic do_program(int b, int p, int n, bit collide, string req);
    do_load(b, p, n, collide);
    if (collide) begin
      cmd_valid = 1'b1; cmd_op = 3'd3;
      @(negedge clk);
      cmd_valid = 1'b0; wr_valid = 1'b0;
    end else begin
      issue(3, 0, 0);
    end
    confirm_check(req);
  endtask

  task automatic do_erase(int b);
    int n;
    issue(4, b, 0);
    bload = 1'b0;
    busy_len(n);
    chk(n == TE, "R4", "erase busy cycles", n, TE);
    for (int p = 0; p < PGS; p++) bwr[b][p] = 1'b0;
    bptr[b] = 0;
    if (bwear[b] < WMAX) bwear[b]++;
  endtask

  task automatic do_wear(int b, string req);
    issue(5, b, 0);
    bload = 1'b0;
    chk(wear_count == 4'(bwear[b]), req, "erase count", wear_count, bwear[b]);
    chk(sts_fail == 1'b0, "R9", "fail cleared by query", sts_fail, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin
      bptr[b] = 0; bwear[b] = 0;
      for (int p = 0; p < PGS; p++) bwr[b][p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sts_ready == 1'b1, "R1", "ready after reset", sts_ready, 1);
    chk(sts_fail == 1'b0, "R1", "fail after reset", sts_fail, 0);
    chk(wr_ready == 1'b0 && rd_valid == 1'b0, "R1", "streams idle", {wr_ready, rd_valid}, 0);
    do_wear(0, "R1");
    do_wear(1, "R11");
    do_read(1, 5, "R1");

    // R3 full and partial program
    do_program(0, 0, PB, 1'b0, "R3");
    do_read(0, 0, "R3");
    do_program(0, 1, 10, 1'b0, "R3");
    do_read(0, 1, "R3");

    // R5 skip ahead, R6 rewrite, R9 sticky fail
    do_program(0, 5, 4, 1'b0, "R5");
    repeat (7) @(negedge clk);
    chk(sts_fail == 1'b1, "R9", "fail held", sts_fail, 1);
    do_read(0, 5, "R5");
    do_program(0, 0, 6, 1'b0, "R6");
    do_read(0, 0, "R6");
    do_wear(0, "R9");

    // R10 confirm without a load directly before
    issue(3, 0, 2);
    confirm_check("R10");
    do_load(0, 2, 4, 1'b0);
    do_wear(0, "R11");
    issue(3, 0, 2);
    confirm_check("R10");

    // R8 erase held on the port through a program's busy time
    do_load(0, 2, PB, 1'b0);
    issue(3, 0, 0);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_block = 1'b0;
    confirm_check("R8");
    cmd_valid = 1'b0;
    chk(sts_fail == 1'b0, "R8", "fail after ignored erase", sts_fail, 0);
    do_wear(0, "R8");
    do_read(0, 2, "R8");

    // R3 byte handshaken with the confirm edge
    do_program(0, 3, PB, 1'b1, "R3");
    do_read(0, 3, "R3");

    // R4 erase, other block intact, restart at page 0
    do_program(1, 0, PB, 1'b0, "R4");
    do_erase(0);
    do_read(0, 0, "R4");
    do_read(0, 3, "R4");
    do_read(1, 0, "R4");
    do_wear(0, "R11");
    do_program(0, 0, 8, 1'b0, "R4");

    // R7 two sessions with other work between
    for (int p = 1; p < 4; p++) do_program(0, p, 5, 1'b0, "R7");
    do_read(1, 0, "R7");
    do_program(1, 1, 3, 1'b0, "R7");
    for (int p = 4; p < 6; p++) do_program(0, p, 5, 1'b0, "R7");
    do_read(0, 5, "R7");

    // R11 ignored opcodes
    issue(6, 0, 0);
    chk(sts_ready == 1'b1 && sts_fail == 1'b0, "R11", "unknown opcode ignored", sts_ready, 1);

    // Random mix
    for (int it = 0; it < 120; it++) begin
      int r, b, p;
      r = $urandom % 10;
      b = $urandom % NB;
      if (r < 4) begin
        do_read(b, $urandom % PGS, "R2");
      end else if (r < 7) begin
        p = (($urandom % 4) == 0 || bptr[b] >= PGS) ? ($urandom % PGS) : bptr[b];
        do_program(b, p, 1 + ($urandom % PB), 1'(($urandom % 5) == 0), "R5");
      end else if (r == 7) begin
        do_wear(b, "R11");
      end else if (r == 8) begin
        issue(3, 0, 0);
        confirm_check("R10");
      end else if (($urandom % 4) == 0) begin
        do_erase(b);
      end
    end

    // R11 saturation
    while (bwear[1] < WMAX) do_erase(1);
    do_erase(1);
    do_wear(1, "R11");
    do_read(1, 0, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL all watchdog: got %0h expected %0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule